// File: doc/BRIEF.md
# Leaky integrate-and-fire neuron

This block is one discrete-time spiking neuron in fixed point. Each time step it gathers a weighted sum of the binary spikes that the previous layer produced in the step before. The weights and spike bits arrive one input per cycle. It then adds a constant bias, scales the old membrane potential by a leak factor and removes the threshold if the neuron fired in the previous step. It compares the new potential with the threshold to decide whether it fires in this step. The potential is also brought out so that a learning unit next to the neuron can read it.

A caller starts a step with a one-cycle `step_valid` strobe while the neuron is idle. It then supplies the weight and spike bit for the index shown on `in_idx`, one per cycle. After the last input the neuron takes one update cycle and pulses `step_done`. Setting the unity bit turns the leak off, so the same datapath works as a non-leaky integrate-and-fire neuron. A `sample_start` pulse clears the neuron's state between samples.

Top module: `lif_neuron`

## Requirements
- R1: After reset, `membrane_out` is 0 and `spike_out`, `busy` and `step_done` are 0.
- R2: A `step_valid` pulse while idle, and without `sample_start`, makes `busy` high for exactly N_INPUTS+1 cycles. `in_idx` counts 0 to N_INPUTS-1 in the first N_INPUTS of those cycles. `step_done` is high for the single cycle that follows, while `busy` is low.
- R3: The input current of a step is the sign-extended `bias` plus the sum of the signed `in_weight` values sampled while `in_spike` was 1. A weight presented with `in_spike` = 0 adds nothing.
- R4: With `alpha_unity` = 1 the old potential is carried over unscaled. Otherwise it becomes floor(U · `alpha_frac` / 256), where `alpha_frac` is an unsigned fraction with 8 fractional bits, so 0 discards the old potential.
- R5: The signed `threshold` is subtracted from the new potential only when `spike_out` was 1 from the previous step.
- R6: `spike_out` becomes 1 when the new potential, read as signed, is greater than or equal to `threshold`, and 0 otherwise.
- R7: The 24-bit signed potential saturates at +8388607 and at -8388608 instead of wrapping.
- R8: `sample_start` clears the potential and the stored spike to 0 and abandons any step in progress. It wins over a `step_valid` in the same cycle.
- R9: A `step_valid` that arrives while a step is in progress is ignored. No second step follows.
- R10: `membrane_out` and `spike_out` change only in an update cycle or through `sample_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_start | input | 1 | Clears potential and stored spike, aborts a step |
| step_valid | input | 1 | Starts one time step when idle |
| alpha_frac | input | 8 | Leak factor, unsigned fraction with 8 fractional bits |
| alpha_unity | input | 1 | 1 selects a leak factor of exactly one |
| threshold | input | 16 | Signed firing threshold |
| bias | input | 16 | Signed constant input current |
| in_weight | input | 16 | Signed weight of the input named by `in_idx` |
| in_spike | input | 1 | Previous-step spike of the input named by `in_idx` |
| in_idx | output | 3 | Index of the input sampled this cycle |
| busy | output | 1 | Step in progress |
| step_done | output | 1 | One-cycle pulse after the update |
| spike_out | output | 1 | Spike of the latest step |
| membrane_out | output | 24 | Signed membrane potential |

## Verification
The hardest state to reach from the ports is the saturated potential. One step adds at most about a quarter of a million, so the limits at plus or minus eight million can only be reached over many steps. The stimulus runs long chains of steps with unity leak and all inputs spiking at extreme weights. In the positive chain the large threshold is subtracted after every firing step, and the chain still climbs until it clamps. A mirror chain with the most negative weights and bias drives the potential to the lower limit. The stimulus also aborts a step in its middle accumulation cycle, to show that the clear wins over a step half done.

// File: rtl/lif_pkg.sv
package lif_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_UPD  = 2'd2
  } step_state_e;

  // Old potential scaled by the leak factor: floor(u * a / 2^frac).
  function automatic longint leak_apply(input longint u, input longint a,
                                        input int frac, input logic bypass);
    longint prod;
    prod = u * a;
    if (bypass) return u;
    return prod >>> frac;
  endfunction

  // Clamp a wide signed value into a w-bit signed range.
  function automatic longint sat_clamp(input longint v, input int w);
    longint hi;
    longint lo;
    hi = (longint'(1) <<< (w - 1)) - 1;
    lo = -(longint'(1) <<< (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic logic is_above(input longint v, input int w);
    return v > ((longint'(1) <<< (w - 1)) - 1);
  endfunction

  function automatic logic is_below(input longint v, input int w);
    return v < -(longint'(1) <<< (w - 1));
  endfunction

endpackage

// File: rtl/lif_step_ctrl.sv
module lif_step_ctrl
  import lif_pkg::*;
#(
  parameter int N_INPUTS = 8,
  parameter int IDX_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_start,
  input  logic             step_valid,
  output logic [IDX_W-1:0] in_idx,
  output logic             busy,
  output logic             load_evt,
  output logic             acc_evt,
  output logic             upd_evt,
  output logic             step_done
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_INPUTS - 1);

  step_state_e state_q;
  logic [IDX_W-1:0] idx_q;

  assign in_idx   = idx_q;
  assign busy     = (state_q != ST_IDLE);
  assign load_evt = (state_q == ST_IDLE) && step_valid && !sample_start;
  assign acc_evt  = (state_q == ST_ACC) && !sample_start;
  assign upd_evt  = (state_q == ST_UPD) && !sample_start;

  always_ff @(posedge clk) begin
    if (!rst_n || sample_start) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      step_done <= 1'b0;
    end else begin
      step_done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          idx_q <= '0;
          if (step_valid) state_q <= ST_ACC;
        end
        ST_ACC: begin
          if (idx_q == LAST_IDX) state_q <= ST_UPD;
          else                   idx_q   <= idx_q + 1'b1;
        end
        ST_UPD: begin
          state_q   <= ST_IDLE;
          idx_q     <= '0;
          step_done <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lif_accum.sv
module lif_accum #(
  parameter int W_W   = 16,
  parameter int ACC_W = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    load,
  input  logic                    add_en,
  input  logic signed [W_W-1:0]   bias,
  input  logic signed [W_W-1:0]   weight,
  input  logic                    spike_bit,
  output logic signed [ACC_W-1:0] acc
);

  localparam int EXT = ACC_W - W_W;

  logic signed [ACC_W-1:0] bias_ext;
  logic signed [ACC_W-1:0] w_ext;

  assign bias_ext = {{EXT{bias[W_W-1]}}, bias};
  assign w_ext    = spike_bit ? {{EXT{weight[W_W-1]}}, weight} : '0;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) acc <= '0;
    else if (load)       acc <= bias_ext;
    else if (add_en)     acc <= acc + w_ext;
  end

endmodule

// File: rtl/lif_membrane.sv
module lif_membrane
  import lif_pkg::*;
#(
  parameter int U_W     = 24,
  parameter int ACC_W   = 20,
  parameter int TH_W    = 16,
  parameter int ALPHA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    update,
  input  logic signed [ACC_W-1:0] acc,
  input  logic [ALPHA_W-1:0]      alpha_frac,
  input  logic                    alpha_unity,
  input  logic signed [TH_W-1:0]  threshold,
  output logic signed [U_W-1:0]   membrane,
  output logic                    spike,
  output logic                    sat_hi_evt,
  output logic                    sat_lo_evt,
  output logic                    fire_evt
);

  longint leaked;
  longint raw;
  longint clamped;
  logic signed [U_W-1:0] u_next;

  always_comb begin
    leaked  = leak_apply(longint'(membrane), longint'(alpha_frac), ALPHA_W, alpha_unity);
    raw     = leaked + longint'(acc) - (spike ? longint'(threshold) : longint'(0));
    clamped = sat_clamp(raw, U_W);
    u_next  = clamped[U_W-1:0];
    sat_hi_evt = is_above(raw, U_W);
    sat_lo_evt = is_below(raw, U_W);
    fire_evt   = longint'(u_next) >= longint'(threshold);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      membrane <= '0;
      spike    <= 1'b0;
    end else if (update) begin
      membrane <= u_next;
      spike    <= fire_evt;
    end
  end

endmodule

// File: rtl/lif_neuron.sv
module lif_neuron #(
  parameter int N_INPUTS = 8,
  parameter int W_W      = 16,
  parameter int U_W      = 24,
  parameter int ALPHA_W  = 8,
  parameter int IDX_W    = (N_INPUTS > 1) ? $clog2(N_INPUTS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sample_start,
  input  logic                  step_valid,
  input  logic [ALPHA_W-1:0]    alpha_frac,
  input  logic                  alpha_unity,
  input  logic signed [W_W-1:0] threshold,
  input  logic signed [W_W-1:0] bias,
  input  logic signed [W_W-1:0] in_weight,
  input  logic                  in_spike,
  output logic [IDX_W-1:0]      in_idx,
  output logic                  busy,
  output logic                  step_done,
  output logic                  spike_out,
  output logic signed [U_W-1:0] membrane_out
);

  localparam int ACC_W = W_W + $clog2(N_INPUTS + 1) + 1;

  logic load_evt;
  logic acc_evt;
  logic upd_evt;
  logic sat_hi_evt;
  logic sat_lo_evt;
  logic fire_evt;
  logic signed [ACC_W-1:0] acc;

  lif_step_ctrl #(.N_INPUTS(N_INPUTS), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .sample_start(sample_start),
    .step_valid(step_valid), .in_idx(in_idx), .busy(busy),
    .load_evt(load_evt), .acc_evt(acc_evt), .upd_evt(upd_evt),
    .step_done(step_done)
  );

  lif_accum #(.W_W(W_W), .ACC_W(ACC_W)) accum_i (
    .clk(clk), .rst_n(rst_n), .clear(sample_start), .load(load_evt),
    .add_en(acc_evt), .bias(bias), .weight(in_weight),
    .spike_bit(in_spike), .acc(acc)
  );

  lif_membrane #(.U_W(U_W), .ACC_W(ACC_W), .TH_W(W_W), .ALPHA_W(ALPHA_W)) mem_i (
    .clk(clk), .rst_n(rst_n), .clear(sample_start), .update(upd_evt),
    .acc(acc), .alpha_frac(alpha_frac), .alpha_unity(alpha_unity),
    .threshold(threshold), .membrane(membrane_out), .spike(spike_out),
    .sat_hi_evt(sat_hi_evt), .sat_lo_evt(sat_lo_evt), .fire_evt(fire_evt)
  );

endmodule

// File: rtl/lif_neuron_chk.sv
module lif_neuron_chk #(
  parameter int U_W = 24,
  parameter int W_W = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  sample_start,
  input logic                  step_valid,
  input logic                  busy,
  input logic                  step_done,
  input logic                  upd_evt,
  input logic                  sat_hi_evt,
  input logic                  sat_lo_evt,
  input logic signed [W_W-1:0] threshold,
  input logic                  spike_out,
  input logic signed [U_W-1:0] membrane_out
);

  localparam logic signed [U_W-1:0] U_MAX = {1'b0, {(U_W-1){1'b1}}};
  localparam logic signed [U_W-1:0] U_MIN = {1'b1, {(U_W-1){1'b0}}};

  // R2
  step_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && !busy && !sample_start) |=> busy);

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |-> (!busy ##1 !step_done));

  // R6
  fire_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |-> (spike_out == (membrane_out >= $past(threshold))));

  // R7
  sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_evt && sat_hi_evt) |=> (membrane_out == U_MAX));

  // R7
  sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_evt && sat_lo_evt) |=> (membrane_out == U_MIN));

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_start |=> (membrane_out == '0 && !spike_out && !busy && !step_done));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_evt && !sample_start) |=> ($stable(membrane_out) && $stable(spike_out)));

endmodule

bind lif_neuron lif_neuron_chk #(.U_W(U_W), .W_W(W_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sample_start(sample_start),
  .step_valid(step_valid), .busy(busy), .step_done(step_done),
  .upd_evt(upd_evt), .sat_hi_evt(sat_hi_evt), .sat_lo_evt(sat_lo_evt),
  .threshold(threshold), .spike_out(spike_out), .membrane_out(membrane_out)
);

// File: tb/lif_neuron_tb_top.sv
module lif_neuron_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam longint UMAX = 8388607;
  localparam longint UMIN = -8388608;

  typedef struct packed {
    logic [7:0]         alpha;
    logic               unity;
    logic signed [15:0] th;
    logic signed [15:0] bias;
    logic signed [15:0] wbase;
    logic signed [15:0] wstep;
    logic [7:0]         mask;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'd0,   1'b1, 16'sd300,  16'sd10,   16'sd50,   16'sd10,  8'hFF},
    '{8'd0,   1'b1, 16'sd300,  16'sd0,    16'sd20,   16'sd0,   8'h0F},
    '{8'd128, 1'b0, 16'sd300,  16'sd5,    16'sd40,   -16'sd5,  8'hA5},
    '{8'd128, 1'b0, 16'sd300,  -16'sd700, 16'sd1,    16'sd0,   8'h00},
    '{8'd128, 1'b0, 16'sd300,  16'sd0,    -16'sd3,   16'sd0,   8'h01},
    '{8'd255, 1'b0, 16'sd100,  16'sd0,    16'sd30,   16'sd1,   8'h3C},
    '{8'd0,   1'b0, 16'sd100,  16'sd7,    16'sd12,   16'sd3,   8'h81},
    '{8'd200, 1'b0, -16'sd50,  -16'sd20,  16'sd0,    16'sd0,   8'h00},
    '{8'd64,  1'b0, 16'sd500,  16'sd100,  -16'sd200, 16'sd60,  8'hFF},
    '{8'd0,   1'b1, 16'sd500,  16'sd0,    16'sd70,   16'sd70,  8'hF0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_start = 1'b0;
  logic step_valid = 1'b0;
  logic [7:0] alpha_frac = '0;
  logic alpha_unity = 1'b1;
  logic signed [15:0] threshold = 16'sd300;
  logic signed [15:0] bias = '0;
  logic signed [15:0] in_weight;
  logic in_spike;
  logic [2:0] in_idx;
  logic busy, step_done, spike_out;
  logic signed [23:0] membrane_out;

  logic signed [15:0] tb_w [N];
  logic [N-1:0] tb_mask = '0;

  assign in_weight = tb_w[in_idx];
  assign in_spike  = tb_mask[in_idx];

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  longint m_u = 0;
  bit m_s = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lif_neuron dut_i (
    .clk(clk), .rst_n(rst_n), .sample_start(sample_start),
    .step_valid(step_valid), .alpha_frac(alpha_frac),
    .alpha_unity(alpha_unity), .threshold(threshold), .bias(bias),
    .in_weight(in_weight), .in_spike(in_spike), .in_idx(in_idx),
    .busy(busy), .step_done(step_done), .spike_out(spike_out),
    .membrane_out(membrane_out)
  );

  task automatic check(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Independent model of one step, written from the requirements.
  task automatic model_step();
    longint cur, prod, leak, tot;
    cur = longint'(bias);
    for (int k = 0; k < N; k++) if (tb_mask[k]) cur += longint'(tb_w[k]);
    if (alpha_unity) leak = m_u;
    else begin
      prod = m_u * longint'(alpha_frac);
      if (prod >= 0) leak = prod / 256;
      else leak = -((-prod + 255) / 256);
    end
    tot = leak + cur;
    if (m_s) tot -= longint'(threshold);
    if (tot > UMAX) tot = UMAX;
    if (tot < UMIN) tot = UMIN;
    m_u = tot;
    m_s = (tot >= longint'(threshold));
  endtask

  task automatic run_step(input string req);
    int bc;
    int guard;
    @(negedge clk);
    step_valid = 1'b1;
    @(negedge clk);
    step_valid = 1'b0;
    bc = 0;
    guard = 0;
    while (!step_done && guard < 4*N) begin
      if (busy) bc++;
      check("R2 in_idx", longint'(in_idx), (bc >= 1 && bc <= N) ? longint'(bc - 1) : longint'(in_idx));
      guard++;
      @(negedge clk);
    end
    check("R2 busy length", bc, N + 1);
    check("R2 done with busy low", busy, 0);
    model_step();
    check({req, " membrane"}, longint'(membrane_out), m_u);
    check({req, " spike"}, longint'(spike_out), longint'(m_s));
  endtask

  task automatic load_vec(input vec_t v);
    alpha_frac  = v.alpha;
    alpha_unity = v.unity;
    threshold   = v.th;
    bias        = v.bias;
    tb_mask     = v.mask;
    for (int k = 0; k < N; k++) tb_w[k] = 16'(v.wbase + v.wstep * 16'(k));
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    sample_start = 1'b1;
    @(negedge clk);
    sample_start = 1'b0;
    m_u = 0;
    m_s = 0;
  endtask

  initial begin
    for (int k = 0; k < N; k++) tb_w[k] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 membrane", longint'(membrane_out), 0);
    check("R1 spike", spike_out, 0);
    check("R1 busy", busy, 0);
    check("R1 done", step_done, 0);
    rst_n = 1'b1;

    // Vector walk: R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      load_vec(VECS[i]);
      run_step("R3/R4/R5/R6 vector");
    end

    // R10: outputs hold while idle and config changes
    begin
      longint held;
      held = longint'(membrane_out);
      @(negedge clk);
      bias = 16'sd999; alpha_unity = 1'b0; alpha_frac = 8'd3;
      repeat (5) @(negedge clk);
      check("R10 hold", longint'(membrane_out), held);
    end

    // R3: weights with spike 0 are ignored
    pulse_clear();
    load_vec('{8'd0, 1'b1, 16'sd30000, 16'sd0, 16'sd1000, 16'sd0, 8'h00});
    run_step("R3 silent inputs");
    check("R3 silent value", longint'(membrane_out), 0);

    // R7: drive to positive saturation
    pulse_clear();
    load_vec('{8'd0, 1'b1, 16'sd32767, 16'sd32767, 16'sd32767, 16'sd0, 8'hFF});
    for (int s = 0; s < 40; s++) run_step("R7 high");
    check("R7 high limit", longint'(membrane_out), UMAX);

    // R7: drive to negative saturation
    pulse_clear();
    load_vec('{8'd0, 1'b1, 16'sd32767, -16'sd32768, -16'sd32768, 16'sd0, 8'hFF});
    for (int s = 0; s < 35; s++) run_step("R7 low");
    check("R7 low limit", longint'(membrane_out), UMIN);

    // R8: clear aborts a step in progress
    load_vec('{8'd0, 1'b1, 16'sd300, 16'sd50, 16'sd100, 16'sd0, 8'hFF});
    pulse_clear();
    run_step("R8 prep");
    @(negedge clk); step_valid = 1'b1;
    @(negedge clk); step_valid = 1'b0;
    repeat (3) @(negedge clk);
    sample_start = 1'b1;
    @(negedge clk); sample_start = 1'b0;
    m_u = 0; m_s = 0;
    check("R8 membrane cleared", longint'(membrane_out), 0);
    check("R8 spike cleared", spike_out, 0);
    check("R8 busy cleared", busy, 0);
    begin
      int saw_done = 0;
      for (int c = 0; c < 2*N; c++) begin
        if (step_done || busy) saw_done++;
        @(negedge clk);
      end
      check("R8 no late done", saw_done, 0);
    end

    // R8: clear wins over simultaneous step_valid
    @(negedge clk); step_valid = 1'b1; sample_start = 1'b1;
    @(negedge clk); step_valid = 1'b0; sample_start = 1'b0;
    check("R8 priority busy", busy, 0);

    // R9: step_valid while busy is ignored
    @(negedge clk); step_valid = 1'b1;
    @(negedge clk); step_valid = 1'b0;
    repeat (3) @(negedge clk);
    step_valid = 1'b1;
    @(negedge clk); step_valid = 1'b0;
    while (!step_done) @(negedge clk);
    model_step();
    check("R9 single step value", longint'(membrane_out), m_u);
    begin
      int extra = 0;
      for (int c = 0; c < 2*N; c++) begin
        @(negedge clk);
        if (busy) extra++;
      end
      check("R9 no second step", extra, 0);
      check("R9 value unchanged", longint'(membrane_out), m_u);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule